// File: doc/BRIEF.md
# Wired-AND Bus Transmit Arbiter and Read-Back Monitor

This block places one node's outgoing bits onto a shared open-drain serial bus and checks each of them against the bus as it is actually seen. The bus follows wired-AND rules. Level 0 is dominant, meaning the node actively pulls the line. Level 1 is recessive, meaning the node lets go of the line and any other node may pull it low. A bit timing unit elsewhere supplies two one-cycle strobes for every bit. The first marks the start of the bit, and the second marks the sample point, which sits roughly two thirds of the way into the bit. The same unit also supplies the bus level seen at that sample point.

Bits arrive on a valid/ready stream. The block takes one bit at each bit-start strobe. `tx_ready` is asserted only in a bit-start cycle, and only while the node has not lost arbitration or a new frame is being started in that cycle. A bit moves only when `tx_valid` and `tx_ready` are high in the same cycle. The source may hold `tx_valid` high as long as it likes, because nothing is consumed between strobes. If no bit is offered at a bit start, that bit stays recessive and is not checked.

At the sample point the block compares the bus level with the bit it sent. During the arbitration field, sending recessive and reading dominant means another node has won. The block then withdraws without any error report. It stays recessive and refuses further bits until the upper layer starts a new frame. Any other mismatch is reported as a one-cycle bit error pulse.

Top module: `busarb_tx_monitor`

## Requirements
- R1: Out of reset, `tx_pin` is 1 (recessive), and `arb_lost` and `bit_error` are both 0.
- R2: `tx_ready` equals `bit_start` and not (`arb_lost` and not `frame_start`). When `tx_valid` and `tx_ready` are both high at a clock edge, `tx_pin` takes `tx_bit` from the next cycle on, with 0 meaning drive dominant and 1 meaning release.
- R3: `tx_pin` changes only on the clock edge that ends a `bit_start` cycle. It holds its value through the sample point.
- R4: The arbitration-field flag is `arb_field`, captured at the accepted bit start. If a bit sent as 1 inside the arbitration field reads back 0 at `sample_pt`, `arb_lost` is 1 from the next cycle, and `bit_error` stays 0.
- R5: While `arb_lost` is 1 and `frame_start` is 0, every bit start keeps `tx_pin` at 1 with `tx_ready` at 0, and `arb_lost` stays 1. `frame_start` clears `arb_lost` at the next edge, and a bit offered in that same cycle is accepted.
- R6: If a bit sent as 1 outside the arbitration field reads back 0, `bit_error` is 1 for exactly one cycle, `arb_lost` is unchanged, and the next bits are still accepted.
- R7: If a bit sent as 0 reads back 1, `bit_error` pulses for one cycle, whatever `arb_field` was.
- R8: A read-back that matches the sent bit, for either bit value and in either field, raises neither flag.
- R9: Only the first `sample_pt` of a bit is judged. A `sample_pt` in the same cycle as `bit_start` is ignored.
- R10: A bit start with no accepted bit leaves `tx_pin` at 1, and no read-back during that bit raises a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_start | input | 1 | One-cycle strobe at the start of each bit |
| sample_pt | input | 1 | One-cycle strobe at the sample point of each bit |
| bus_rx | input | 1 | Bus level at the sample point (0 dominant) |
| frame_start | input | 1 | Upper layer begins a new frame; clears arbitration loss |
| arb_field | input | 1 | Offered bit belongs to the arbitration field |
| tx_valid | input | 1 | Stream: a bit is offered |
| tx_bit | input | 1 | Stream: the offered bit value |
| tx_ready | output | 1 | Stream: the bit is taken in this cycle |
| tx_pin | output | 1 | Transmit level (0 drive dominant, 1 release) |
| arb_lost | output | 1 | Arbitration lost; held until a new frame starts |
| bit_error | output | 1 | One-cycle pulse on a read-back mismatch that is a fault |

## Verification
Every combination of sent bit and read-back level is tried both inside and outside the arbitration field. This separates a silent withdrawal (recessive sent, dominant read, arbitration field) from the two kinds of bit error and from clean matches. A loss is followed by further offered bits and then a new frame, to show the lock-out and its release. Idle bits with a dominant bus, repeated sample strobes and a sample strobe coinciding with a bit start confirm that only one judged read-back happens per launched bit.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;

  typedef enum logic [1:0] {
    RB_MATCH = 2'd0,
    RB_LOST  = 2'd1,
    RB_FAULT = 2'd2
  } rb_verdict_e;
endpackage

// File: rtl/busarb_launch.sv
module busarb_launch
  import busarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_start,
  input  logic frame_start,
  input  logic tx_valid,
  input  logic tx_bit,
  input  logic arb_field,
  input  logic lost,
  output logic tx_ready,
  output logic tx_pin,
  output logic bit_live,
  output logic bit_arb
);
  logic blocked;
  logic take;

  assign blocked  = lost & ~frame_start;
  assign tx_ready = bit_start & ~blocked;
  assign take     = tx_ready & tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pin   <= LVL_REC;
      bit_live <= 1'b0;
      bit_arb  <= 1'b0;
    end else if (bit_start) begin
      if (take) begin
        tx_pin   <= tx_bit;
        bit_live <= 1'b1;
        bit_arb  <= arb_field;
      end else begin
        tx_pin   <= LVL_REC;
        bit_live <= 1'b0;
        bit_arb  <= 1'b0;
      end
    end
  end

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start && !take) |=> (tx_pin == LVL_REC && !bit_live));
endmodule

// File: rtl/busarb_readback.sv
module busarb_readback
  import busarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_start,
  input  logic sample_pt,
  input  logic frame_start,
  input  logic bus_rx,
  input  logic tx_pin,
  input  logic bit_live,
  input  logic bit_arb,
  output logic lost,
  output logic bit_error
);
  rb_verdict_e verdict;
  logic        checked;
  logic        judge;

  always_comb begin
    verdict = RB_MATCH;
    if (tx_pin == LVL_REC && bus_rx == LVL_DOM)
      verdict = bit_arb ? RB_LOST : RB_FAULT;
    else if (tx_pin == LVL_DOM && bus_rx == LVL_REC)
      verdict = RB_FAULT;
  end

  assign judge = sample_pt & ~bit_start & bit_live & ~checked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost      <= 1'b0;
      bit_error <= 1'b0;
      checked   <= 1'b0;
    end else begin
      bit_error <= judge && (verdict == RB_FAULT);
      if (bit_start)  checked <= 1'b0;
      else if (judge) checked <= 1'b1;
      if (frame_start)                        lost <= 1'b0;
      else if (judge && verdict == RB_LOST)   lost <= 1'b1;
    end
  end

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_error |=> !bit_error);

  // R4
  silent_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> !bit_error);
endmodule

// File: rtl/busarb_tx_monitor.sv
module busarb_tx_monitor
  import busarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_start,
  input  logic sample_pt,
  input  logic bus_rx,
  input  logic frame_start,
  input  logic arb_field,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready,
  output logic tx_pin,
  output logic arb_lost,
  output logic bit_error
);
  logic bit_live;
  logic bit_arb;

  busarb_launch u_launch (
    .clk(clk), .rst_n(rst_n), .bit_start(bit_start), .frame_start(frame_start),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .arb_field(arb_field), .lost(arb_lost),
    .tx_ready(tx_ready), .tx_pin(tx_pin), .bit_live(bit_live), .bit_arb(bit_arb)
  );

  busarb_readback u_readback (
    .clk(clk), .rst_n(rst_n), .bit_start(bit_start), .sample_pt(sample_pt),
    .frame_start(frame_start), .bus_rx(bus_rx), .tx_pin(tx_pin),
    .bit_live(bit_live), .bit_arb(bit_arb), .lost(arb_lost), .bit_error(bit_error)
  );

  // R3
  pin_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_start |=> $stable(tx_pin));

  // R5
  lost_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (tx_pin == LVL_REC));

  // R5
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !frame_start) |=> arb_lost);

  // R5
  lost_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !frame_start) |-> !tx_ready);
endmodule

// File: tb/busarb_tx_monitor_bench.sv
module busarb_tx_monitor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_start = 1'b0, sample_pt = 1'b0, bus_rx = 1'b1, frame_start = 1'b0;
  logic arb_field = 1'b0, tx_valid = 1'b0, tx_bit = 1'b1;
  logic tx_ready, tx_pin, arb_lost, bit_error;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  busarb_tx_monitor u_busarb_tx_monitor (
    .clk(clk), .rst_n(rst_n), .bit_start(bit_start), .sample_pt(sample_pt),
    .bus_rx(bus_rx), .frame_start(frame_start), .arb_field(arb_field),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready), .tx_pin(tx_pin),
    .arb_lost(arb_lost), .bit_error(bit_error)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // One full bit: launch, settle, one sample, observe flags and the pulse end.
  task automatic do_bit(input logic v, input logic b, input logic a, input logic fs,
                        input logic rx, output logic rdy, output logic pin,
                        output logic pin_late, output logic lost, output logic err,
                        output logic err_next);
    @(negedge clk);
    bit_start = 1; tx_valid = v; tx_bit = b; arb_field = a; frame_start = fs;
    #1 rdy = tx_ready;
    @(negedge clk);
    bit_start = 0; tx_valid = 0; frame_start = 0; arb_field = 0;
    pin = tx_pin;
    @(negedge clk);
    sample_pt = 1; bus_rx = rx;
    @(negedge clk);
    sample_pt = 0; bus_rx = 1;
    pin_late = tx_pin; lost = arb_lost; err = bit_error;
    @(negedge clk);
    err_next = bit_error;
  endtask

  task automatic t_reset();
    check("R1", "tx_pin", tx_pin, 1'b1);
    check("R1", "arb_lost", arb_lost, 1'b0);
    check("R1", "bit_error", bit_error, 1'b0);
  endtask

  task automatic t_clean();
    logic rdy, pin, pl, lo, er, en;
    for (int k = 0; k < 4; k++) begin
      logic bb = k[0];
      logic aa = k[1];
      do_bit(1, bb, aa, 0, bb, rdy, pin, pl, lo, er, en);
      check("R2", "tx_ready at bit start", rdy, 1'b1);
      check("R2", "tx_pin follows bit", pin, bb);
      check("R3", "tx_pin held at sample", pl, bb);
      check("R8", "no lost on match", lo, 1'b0);
      check("R8", "no error on match", er, 1'b0);
    end
  endtask

  task automatic t_arb_loss();
    logic rdy, pin, pl, lo, er, en;
    do_bit(1, 1, 1, 0, 0, rdy, pin, pl, lo, er, en);
    check("R4", "arb_lost set", lo, 1'b1);
    check("R4", "no bit_error on loss", er, 1'b0);
    check("R4", "tx_pin recessive", pl, 1'b1);
    do_bit(1, 0, 1, 0, 0, rdy, pin, pl, lo, er, en);
    check("R5", "tx_ready blocked", rdy, 1'b0);
    check("R5", "tx_pin stays recessive", pin, 1'b1);
    check("R5", "arb_lost held", lo, 1'b1);
    check("R5", "no error while lost", er, 1'b0);
    do_bit(1, 0, 0, 1, 0, rdy, pin, pl, lo, er, en);
    check("R5", "ready with frame_start", rdy, 1'b1);
    check("R5", "new frame drives bit", pin, 1'b0);
    check("R5", "arb_lost cleared", lo, 1'b0);
  endtask

  task automatic t_late_mismatch();
    logic rdy, pin, pl, lo, er, en;
    do_bit(1, 1, 0, 0, 0, rdy, pin, pl, lo, er, en);
    check("R6", "bit_error pulse", er, 1'b1);
    check("R6", "pulse one cycle", en, 1'b0);
    check("R6", "arb_lost unchanged", lo, 1'b0);
    do_bit(1, 0, 0, 0, 0, rdy, pin, pl, lo, er, en);
    check("R6", "next bit accepted", rdy, 1'b1);
    check("R6", "next bit driven", pin, 1'b0);
  endtask

  task automatic t_stuck_recessive();
    logic rdy, pin, pl, lo, er, en;
    for (int aa = 0; aa < 2; aa++) begin
      do_bit(1, 0, aa[0], 0, 1, rdy, pin, pl, lo, er, en);
      check("R7", "bit_error on dominant lost", er, 1'b1);
      check("R7", "pulse ends", en, 1'b0);
      check("R7", "no arb_lost", lo, 1'b0);
    end
  endtask

  task automatic t_idle();
    logic rdy, pin, pl, lo, er, en;
    tx_bit = 0;
    do_bit(0, 0, 1, 0, 0, rdy, pin, pl, lo, er, en);
    check("R10", "idle tx_pin recessive", pin, 1'b1);
    check("R10", "idle no lost", lo, 1'b0);
    check("R10", "idle no error", er, 1'b0);
  endtask

  task automatic t_sample_once();
    // accept a 0 bit, first sample matches, second would mismatch
    @(negedge clk);
    bit_start = 1; tx_valid = 1; tx_bit = 0; arb_field = 0;
    @(negedge clk);
    bit_start = 0; tx_valid = 0;
    sample_pt = 1; bus_rx = 0;
    @(negedge clk);
    bus_rx = 1;
    @(negedge clk);
    sample_pt = 0;
    check("R9", "second sample ignored", bit_error, 1'b0);
    @(negedge clk);
    check("R9", "second sample ignored later", bit_error, 1'b0);
    // sample coinciding with bit start is ignored
    @(negedge clk);
    bit_start = 1; sample_pt = 1; tx_valid = 1; tx_bit = 0; bus_rx = 1;
    @(negedge clk);
    bit_start = 0; sample_pt = 0; tx_valid = 0;
    check("R9", "sample at bit start ignored", bit_error, 1'b0);
    check("R9", "bit driven", tx_pin, 1'b0);
    @(negedge clk);
    sample_pt = 1; bus_rx = 1;
    @(negedge clk);
    sample_pt = 0;
    check("R9", "real sample judged", bit_error, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_clean();
    t_arb_loss();
    t_late_mismatch();
    t_stuck_recessive();
    t_idle();
    t_sample_once();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule